// File: doc/BRIEF.md
# Incremental Encoder Counter Channel

This block is one counter channel for an incremental position encoder with two phase tracks (A, B) and a reference track (C). The tracks are decoded either as a plain up/down pulse counter or as a quadrature pair evaluated once, twice or four times per signal period. The result drives a signed count register of parameterised width. A load register holds a preset value, and two latch registers take snapshots of the count.

Each load, clear and latch action has two kinds of trigger. Software triggers come through a write-only control word. Hardware triggers are chosen by fields in a mode word. They include the timer zero-crossing pulse, a software sync pulse shared by all channels, a common sync-in pulse, a per-channel external input, and reference-mark events. Reference-mark events can be restricted to the next mark after arming, to the second mark, or to every mark. Two sticky flags record whether the first and second marks have been crossed since the last arm command.

Top module: `enc_count_channel`

## Requirements
- R1: After reset the count, both latch values and both traversed flags are zero.
- R2: Mode word bits [1:0]=0 select the plain counter. Each rising edge of the effective B track steps the count: up when effective A is 0, down when it is 1. A rising edge of C is the reference mark in this mode.
- R3: Mode word bits [1:0]=1, 2 and 3 select quadrature decoding. The count moves by 1, 2 or 4 per full A/B period. It counts up when A leads B (A,B sequence 00,10,11,01) and down for the reverse sequence.
- R4: Mode word bit [2] reverses the counting direction in every decoding mode.
- R5: Mode word bit [3] inverts A and B before decoding. In quadrature modes a reference mark is the moment C=1 coincides with effective A=1 and B=1. That is raw A=B=1 when not inverted and raw A=B=0 when inverted. C high in any other track state is not a mark.
- R6: A control write with bit 0 set clears the count, bit 1 copies the load register into the count, bit 2 latches into latch 0, bit 3 latches into latch 1, and bit 4 arms the reference logic. Clear wins over load when both are set.
- R7: Writing the load register does not change the count.
- R8: Arming clears both traversed flags. The first mark after arming sets the first flag and the next mark sets the second flag. The second flag is never set without the first.
- R9: Mode word bits [6:4] choose the hardware load/clear source. The encodings are: 0 none, 1 clear on next mark, 2 clear on every mark, 3 clear on timer pulse, 4 load on next mark, 5 load on every mark, 6 clear on every mark plus load at negative zero crossing, 7 load on the external load input. All other triggers have no effect on the count.
- R10: With source 6, a downward step taken while the count is zero loads the load register instead of producing -1.
- R11: Mode word bits [9:7] choose the latch 0 hardware trigger and bits [12:10] the latch 1 trigger. The encodings are: 0 none, 1 software sync, 2 timer pulse, 3 sync-in, 4 external latch input, 5 next mark, 6 second mark, 7 every mark. Triggers that are not selected leave the latch unchanged.
- R12: A latch shows, from the cycle after its trigger, the count present during the trigger cycle. This holds even when the count steps in that same cycle.
- R13: Mark-driven sources act only while armed. A next-mark source fires once per arm, and a second-mark source fires only on the second mark after arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trk_a_i | input | 1 | Track A, already synchronised |
| trk_b_i | input | 1 | Track B, already synchronised |
| trk_c_i | input | 1 | Reference track C, already synchronised |
| ext_load_i | input | 1 | External load pulse for this channel |
| ext_latch_i | input | 1 | External latch pulse for this channel |
| tmr_zero_i | input | 1 | Timer zero-crossing pulse |
| sw_sync_i | input | 1 | Software sync pulse shared by channels |
| sync_in_i | input | 1 | Common sync-in pulse |
| mode_we_i | input | 1 | Mode word write strobe |
| mode_wdata_i | input | 13 | Mode word value |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 5 | Control word value (one-shot actions) |
| load_we_i | input | 1 | Load register write strobe |
| load_wdata_i | input | CNT_W | Load register value |
| count_o | output | CNT_W | Current count |
| latch0_o | output | CNT_W | Latch 0 value |
| latch1_o | output | CNT_W | Latch 1 value |
| ref1_seen_o | output | 1 | First mark crossed since arm |
| ref2_seen_o | output | 1 | Second mark crossed since arm |

## Verification
A wrong edge decode or direction decision shows on count_o one cycle after the offending track transition. Over a sweep of whole track periods, the error builds into a total that differs from the multiple of the period count that the sweep predicts. A wrong armed or traversed state shows on the traversed flags at the next mark. It also shows as a load, clear or latch that fires on the wrong mark, and that appears on count_o or a latch output in the following cycle. Latch capture timing is checked by stepping the count and firing the trigger in the same cycle, so an extra register stage appears as an off-by-one latch value.

// File: rtl/enc_count_pkg.sv
package enc_count_pkg;

  localparam int unsigned MODE_W  = 13;
  localparam int unsigned CTL_W   = 5;
  localparam int unsigned N_LATCH = 2;

  // control word bit positions
  localparam int unsigned CTL_CLR  = 0;
  localparam int unsigned CTL_LOAD = 1;
  localparam int unsigned CTL_LAT0 = 2;
  localparam int unsigned CTL_LAT1 = 3;
  localparam int unsigned CTL_ARM  = 4;

  typedef enum logic [1:0] {
    DEC_PLAIN = 2'd0,
    DEC_X1    = 2'd1,
    DEC_X2    = 2'd2,
    DEC_X4    = 2'd3
  } dec_mode_e;

  typedef enum logic [2:0] {
    LC_OFF         = 3'd0,
    LC_CLR_NEXT    = 3'd1,
    LC_CLR_EVERY   = 3'd2,
    LC_CLR_TMR     = 3'd3,
    LC_LD_NEXT     = 3'd4,
    LC_LD_EVERY    = 3'd5,
    LC_CLR_LD_NEG  = 3'd6,
    LC_LD_EXT      = 3'd7
  } lc_src_e;

  typedef enum logic [2:0] {
    LT_OFF    = 3'd0,
    LT_SW     = 3'd1,
    LT_TMR    = 3'd2,
    LT_SYNC   = 3'd3,
    LT_EXT    = 3'd4,
    LT_NEXT   = 3'd5,
    LT_SECOND = 3'd6,
    LT_EVERY  = 3'd7
  } lt_src_e;

  typedef struct packed {
    lt_src_e   lt1;
    lt_src_e   lt0;
    lc_src_e   lc;
    logic      trk_inv;
    logic      dir_inv;
    dec_mode_e dec;
  } mode_t;

endpackage

// File: rtl/enc_track_decoder.sv
module enc_track_decoder
  import enc_count_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      a_i,
  input  logic      b_i,
  input  logic      c_i,
  input  dec_mode_e dec_i,
  input  logic      trk_inv_i,
  input  logic      dir_inv_i,
  output logic      step_o,
  output logic      up_o,
  output logic      mark_o
);

  logic a_p, b_p, cond_p;
  logic a_eff, b_eff, a_edge, b_edge, phase, up_raw, cond;

  always_comb begin
    a_eff  = a_i ^ trk_inv_i;
    b_eff  = b_i ^ trk_inv_i;
    a_edge = a_i ^ a_p;
    b_edge = b_i ^ b_p;
    phase  = a_eff ^ b_eff;
    step_o = 1'b0;
    up_raw = 1'b0;
    unique case (dec_i)
      DEC_PLAIN: begin
        step_o = b_edge & b_eff;
        up_raw = ~a_eff;
      end
      DEC_X1: begin
        step_o = a_edge & a_eff & ~b_edge;
        up_raw = phase;
      end
      DEC_X2: begin
        step_o = a_edge & ~b_edge;
        up_raw = phase;
      end
      DEC_X4: begin
        // simultaneous change of both tracks is not a valid step
        step_o = a_edge ^ b_edge;
        up_raw = a_edge ? phase : ~phase;
      end
      default: ;
    endcase
    up_o   = up_raw ^ dir_inv_i;
    cond   = (dec_i == DEC_PLAIN) ? c_i : (c_i & a_eff & b_eff);
    mark_o = cond & ~cond_p;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_p    <= 1'b0;
      b_p    <= 1'b0;
      cond_p <= 1'b0;
    end else begin
      a_p    <= a_i;
      b_p    <= b_i;
      cond_p <= cond;
    end
  end

  AST_MARK_NEEDS_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_o |-> c_i); // R5

endmodule

// File: rtl/enc_ref_tracker.sv
module enc_ref_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic mark_i,
  output logic next_o,
  output logic second_o,
  output logic every_o,
  output logic ref1_o,
  output logic ref2_o
);

  logic armed_q, r1_q, r2_q;
  logic hit;

  // a mark coinciding with an arm command is dropped
  assign hit      = mark_i & armed_q & ~arm_i;
  assign next_o   = hit & ~r1_q;
  assign second_o = hit & r1_q & ~r2_q;
  assign every_o  = hit;
  assign ref1_o   = r1_q;
  assign ref2_o   = r2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      r1_q    <= 1'b0;
      r2_q    <= 1'b0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      r1_q    <= 1'b0;
      r2_q    <= 1'b0;
    end else if (next_o) begin
      r1_q <= 1'b1;
    end else if (second_o) begin
      r2_q <= 1'b1;
    end
  end

  AST_SECOND_NEEDS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r2_q |-> r1_q); // R8

  AST_ARM_CLEARS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (!r1_q && !r2_q)); // R8

endmodule

// File: rtl/enc_count_core.sv
module enc_count_core
  import enc_count_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             up_i,
  input  lc_src_e          src_i,
  input  logic             next_i,
  input  logic             every_i,
  input  logic             tmr_i,
  input  logic             ext_load_i,
  input  logic             sw_clr_i,
  input  logic             sw_load_i,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_wdata_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] cnt_q, ld_q;
  logic hw_clr, hw_ld, neg_zero, any_set;

  always_comb begin
    neg_zero = step_i & ~up_i & (cnt_q == '0);
    hw_clr   = 1'b0;
    hw_ld    = 1'b0;
    unique case (src_i)
      LC_OFF:        ;
      LC_CLR_NEXT:   hw_clr = next_i;
      LC_CLR_EVERY:  hw_clr = every_i;
      LC_CLR_TMR:    hw_clr = tmr_i;
      LC_LD_NEXT:    hw_ld  = next_i;
      LC_LD_EVERY:   hw_ld  = every_i;
      LC_CLR_LD_NEG: begin
        hw_clr = every_i;
        hw_ld  = neg_zero;
      end
      LC_LD_EXT:     hw_ld  = ext_load_i;
      default: ;
    endcase
    any_set = sw_clr_i | sw_load_i | hw_clr | hw_ld;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ld_q  <= '0;
    end else begin
      if (load_we_i) ld_q <= load_wdata_i;
      if (sw_clr_i)       cnt_q <= '0;
      else if (sw_load_i) cnt_q <= ld_q;
      else if (hw_clr)    cnt_q <= '0;
      else if (hw_ld)     cnt_q <= ld_q;
      else if (step_i)    cnt_q <= up_i ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
    end
  end

  assign count_o = cnt_q;

  AST_SW_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_clr_i |=> (cnt_q == '0)); // R6

  AST_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_set |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1))
                  || (cnt_q == $past(cnt_q) - CNT_W'(1)))); // R3

  AST_LOAD_WRITE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_we_i && !any_set && !step_i) |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/enc_latch_unit.sv
module enc_latch_unit
  import enc_count_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  lt_src_e          src_i,
  input  logic             sw_i,
  input  logic             sw_sync_i,
  input  logic             tmr_i,
  input  logic             sync_in_i,
  input  logic             ext_i,
  input  logic             next_i,
  input  logic             second_i,
  input  logic             every_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] latch_o
);

  logic sel, trig;

  always_comb begin
    sel = 1'b0;
    unique case (src_i)
      LT_OFF:    ;
      LT_SW:     sel = sw_sync_i;
      LT_TMR:    sel = tmr_i;
      LT_SYNC:   sel = sync_in_i;
      LT_EXT:    sel = ext_i;
      LT_NEXT:   sel = next_i;
      LT_SECOND: sel = second_i;
      LT_EVERY:  sel = every_i;
      default: ;
    endcase
    trig = sw_i | sel;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   latch_o <= '0;
    else if (trig) latch_o <= count_i;
  end

  AST_LATCH_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> (latch_o == $past(count_i))); // R12

endmodule

// File: rtl/enc_count_channel.sv
module enc_count_channel
  import enc_count_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trk_a_i,
  input  logic              trk_b_i,
  input  logic              trk_c_i,
  input  logic              ext_load_i,
  input  logic              ext_latch_i,
  input  logic              tmr_zero_i,
  input  logic              sw_sync_i,
  input  logic              sync_in_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              ctrl_we_i,
  input  logic [CTL_W-1:0]  ctrl_wdata_i,
  input  logic              load_we_i,
  input  logic [CNT_W-1:0]  load_wdata_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  latch0_o,
  output logic [CNT_W-1:0]  latch1_o,
  output logic              ref1_seen_o,
  output logic              ref2_seen_o
);

  mode_t            mode_q;
  logic [CTL_W-1:0] ctl;
  logic             step, up, mark;
  logic             ev_next, ev_second, ev_every;
  logic [N_LATCH-1:0] lat_sw;
  lt_src_e            lat_src [N_LATCH];
  logic [CNT_W-1:0]   lat_val [N_LATCH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= '0;
    else if (mode_we_i) mode_q <= mode_t'(mode_wdata_i);
  end

  assign ctl = ctrl_we_i ? ctrl_wdata_i : '0;

  enc_track_decoder i_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_i       (trk_a_i),
    .b_i       (trk_b_i),
    .c_i       (trk_c_i),
    .dec_i     (mode_q.dec),
    .trk_inv_i (mode_q.trk_inv),
    .dir_inv_i (mode_q.dir_inv),
    .step_o    (step),
    .up_o      (up),
    .mark_o    (mark)
  );

  enc_ref_tracker i_ref (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (ctl[CTL_ARM]),
    .mark_i   (mark),
    .next_o   (ev_next),
    .second_o (ev_second),
    .every_o  (ev_every),
    .ref1_o   (ref1_seen_o),
    .ref2_o   (ref2_seen_o)
  );

  enc_count_core #(.CNT_W(CNT_W)) i_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .step_i       (step),
    .up_i         (up),
    .src_i        (mode_q.lc),
    .next_i       (ev_next),
    .every_i      (ev_every),
    .tmr_i        (tmr_zero_i),
    .ext_load_i   (ext_load_i),
    .sw_clr_i     (ctl[CTL_CLR]),
    .sw_load_i    (ctl[CTL_LOAD]),
    .load_we_i    (load_we_i),
    .load_wdata_i (load_wdata_i),
    .count_o      (count_o)
  );

  assign lat_sw     = {ctl[CTL_LAT1], ctl[CTL_LAT0]};
  assign lat_src[0] = mode_q.lt0;
  assign lat_src[1] = mode_q.lt1;

  for (genvar gi = 0; gi < N_LATCH; gi++) begin : g_latch
    enc_latch_unit #(.CNT_W(CNT_W)) i_lat (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_i     (lat_src[gi]),
      .sw_i      (lat_sw[gi]),
      .sw_sync_i (sw_sync_i),
      .tmr_i     (tmr_zero_i),
      .sync_in_i (sync_in_i),
      .ext_i     (ext_latch_i),
      .next_i    (ev_next),
      .second_i  (ev_second),
      .every_i   (ev_every),
      .count_i   (count_o),
      .latch_o   (lat_val[gi])
    );
  end

  assign latch0_o = lat_val[0];
  assign latch1_o = lat_val[1];

endmodule

// File: tb/test_enc_count_channel.sv
module test_enc_count_channel;
  import enc_count_pkg::*;

  localparam int CW = 32;
  localparam logic [4:0] EV_EXTLD = 5'b10000;
  localparam logic [4:0] EV_EXTLT = 5'b01000;
  localparam logic [4:0] EV_TMR   = 5'b00100;
  localparam logic [4:0] EV_SW    = 5'b00010;
  localparam logic [4:0] EV_SYNC  = 5'b00001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_r = 0, b_r = 0, c_r = 0;
  logic ext_ld = 0, ext_lt = 0, tmr = 0, sw_sync = 0, sync_in = 0;
  logic mode_we = 0, ctrl_we = 0, load_we = 0;
  logic [MODE_W-1:0] mode_wdata = '0;
  logic [CTL_W-1:0]  ctrl_wdata = '0;
  logic [CW-1:0]     load_wdata = '0;
  logic [CW-1:0]     count, lat0, lat1;
  logic              ref1, ref2;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  enc_count_channel #(.CNT_W(CW)) i_enc_count_channel (
    .clk_i(clk), .rst_ni(rst_n),
    .trk_a_i(a_r), .trk_b_i(b_r), .trk_c_i(c_r),
    .ext_load_i(ext_ld), .ext_latch_i(ext_lt), .tmr_zero_i(tmr),
    .sw_sync_i(sw_sync), .sync_in_i(sync_in),
    .mode_we_i(mode_we), .mode_wdata_i(mode_wdata),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .load_we_i(load_we), .load_wdata_i(load_wdata),
    .count_o(count), .latch0_o(lat0), .latch1_o(lat1),
    .ref1_seen_o(ref1), .ref2_seen_o(ref2)
  );

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] want);
    total++;
    if (act !== want) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, $signed(act), $signed(want));
    end
  endtask

  function automatic logic [MODE_W-1:0] mw(input logic [1:0] dec, input logic dinv,
      input logic tinv, input logic [2:0] lc, input logic [2:0] lt0, input logic [2:0] lt1);
    return {lt1, lt0, lc, tinv, dinv, dec};
  endfunction

  task automatic trk(input logic a, input logic b, input logic c);
    a_r = a; b_r = b; c_r = c;
    @(negedge clk);
  endtask

  task automatic pulse(input logic [4:0] ev);
    {ext_ld, ext_lt, tmr, sw_sync, sync_in} = ev;
    @(negedge clk);
    {ext_ld, ext_lt, tmr, sw_sync, sync_in} = '0;
  endtask

  task automatic set_mode(input logic [MODE_W-1:0] m);
    mode_we = 1; mode_wdata = m;
    @(negedge clk);
    mode_we = 0;
  endtask

  task automatic ctrl(input logic [CTL_W-1:0] v);
    ctrl_we = 1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 0; ctrl_wdata = '0;
  endtask

  task automatic wr_load(input logic [CW-1:0] v);
    load_we = 1; load_wdata = v;
    @(negedge clk);
    load_we = 0;
  endtask

  task automatic bpulse(input logic a);
    trk(a, 1, 0);
    trk(a, 0, 0);
  endtask

  task automatic cpulse();
    trk(0, 0, 1);
    trk(0, 0, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R1 act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 latch0", lat0, 0);
    chk("R1 latch1", lat1, 0);
    chk("R1 flags", {30'd0, ref2, ref1}, 0);

    // sweep of decode mode x direction invert x track invert
    for (int d = 0; d < 4; d++) begin
      for (int di = 0; di < 2; di++) begin
        for (int ti = 0; ti < 2; ti++) begin
          automatic int f = 3 + d;
          automatic int r = 1 + ti + di;
          automatic int want = 0;
          automatic string tag = (di != 0) ? "R4" : ((d == 0) ? "R2" : "R3");
          set_mode(mw(d[1:0], di[0], ti[0], 3'd0, 3'd0, 3'd0));
          ctrl(5'b00001);
          if (d == 0) begin
            automatic int sp = ((ti ^ di) != 0) ? -1 : 1;
            for (int k = 0; k < f; k++) bpulse(0);
            want = f * sp;
            chk(tag, count, CW'(want));
            for (int k = 0; k < r; k++) bpulse(1);
            trk(0, 0, 0);
            want = want - r * sp;
            chk(tag, count, CW'(want));
          end else begin
            automatic int mult = (d == 1) ? 1 : ((d == 2) ? 2 : 4);
            automatic int sgn = (di != 0) ? -1 : 1;
            for (int k = 0; k < f; k++) begin
              trk(1, 0, 0); trk(1, 1, 0); trk(0, 1, 0); trk(0, 0, 0);
            end
            chk(tag, count, CW'(f * mult * sgn));
            for (int k = 0; k < r; k++) begin
              trk(0, 1, 0); trk(1, 1, 0); trk(1, 0, 0); trk(0, 0, 0);
            end
            chk(tag, count, CW'((f - r) * mult * sgn));
          end
        end
      end
    end

    // software control and load register
    set_mode(mw(2'd0, 0, 0, 3'd0, 3'd0, 3'd0));
    ctrl(5'b00001);
    wr_load(100);
    chk("R7 load write keeps count", count, 0);
    repeat (3) bpulse(0);
    chk("R2 plain up", count, 3);
    ctrl(5'b00010);
    chk("R6 sw load", count, 100);
    ctrl(5'b00011);
    chk("R6 clear wins", count, 0);

    // reference tracking
    cpulse();
    chk("R13 unarmed mark", {31'd0, ref1}, 0);
    ctrl(5'b10000);
    chk("R8 arm flags", {30'd0, ref2, ref1}, 0);
    cpulse();
    chk("R8 first mark", {30'd0, ref2, ref1}, 1);
    cpulse();
    chk("R8 second mark", {30'd0, ref2, ref1}, 3);
    cpulse();
    chk("R8 third mark", {30'd0, ref2, ref1}, 3);
    ctrl(5'b10000);
    chk("R8 rearm clears", {30'd0, ref2, ref1}, 0);

    // load/clear sources
    set_mode(mw(2'd0, 0, 0, 3'd4, 3'd0, 3'd0));
    ctrl(5'b10000);
    cpulse();
    chk("R9 load next", count, 100);
    bpulse(1); bpulse(1);
    chk("R2 plain down", count, 98);
    cpulse();
    chk("R13 load next once", count, 98);
    set_mode(mw(2'd0, 0, 0, 3'd5, 3'd0, 3'd0));
    cpulse();
    chk("R9 load every", count, 100);
    bpulse(1);
    cpulse();
    chk("R9 load every again", count, 100);
    set_mode(mw(2'd0, 0, 0, 3'd1, 3'd0, 3'd0));
    ctrl(5'b10000);
    cpulse();
    chk("R9 clear next", count, 0);
    bpulse(0); bpulse(0);
    cpulse();
    chk("R13 clear next once", count, 2);
    set_mode(mw(2'd0, 0, 0, 3'd2, 3'd0, 3'd0));
    cpulse();
    chk("R9 clear every", count, 0);
    bpulse(0);
    cpulse();
    chk("R9 clear every again", count, 0);
    set_mode(mw(2'd0, 0, 0, 3'd3, 3'd0, 3'd0));
    bpulse(0);
    pulse(EV_EXTLD);
    chk("R9 ext ignored under timer src", count, 1);
    pulse(EV_TMR);
    chk("R9 clear timer", count, 0);
    set_mode(mw(2'd0, 0, 0, 3'd7, 3'd0, 3'd0));
    pulse(EV_EXTLD);
    chk("R9 load ext", count, 100);
    pulse(EV_TMR);
    chk("R9 timer ignored under ext src", count, 100);
    wr_load(50);
    set_mode(mw(2'd0, 0, 0, 3'd6, 3'd0, 3'd0));
    ctrl(5'b00001);
    bpulse(1);
    chk("R10 negative zero load", count, 50);
    bpulse(0);
    chk("R10 up step", count, 51);
    cpulse();
    chk("R10 clear every", count, 0);
    bpulse(1);
    chk("R10 negative zero again", count, 50);

    // latch sources
    set_mode(mw(2'd0, 0, 0, 3'd0, 3'd1, 3'd3));
    ctrl(5'b00001);
    repeat (5) bpulse(0);
    pulse(EV_SW);
    chk("R11 latch0 sw sync", lat0, 5);
    chk("R11 latch1 untouched", lat1, 0);
    pulse(EV_SYNC);
    chk("R11 latch1 sync-in", lat1, 5);
    bpulse(0);
    pulse(EV_TMR);
    chk("R11 timer not selected", lat0, 5);
    set_mode(mw(2'd0, 0, 0, 3'd0, 3'd2, 3'd4));
    pulse(EV_TMR);
    chk("R11 latch0 timer", lat0, 6);
    pulse(EV_EXTLT);
    chk("R11 latch1 ext", lat1, 6);
    chk("R11 latch0 kept", lat0, 6);
    a_r = 0; b_r = 1; tmr = 1;
    @(negedge clk);
    tmr = 0;
    chk("R12 count stepped", count, 7);
    chk("R12 latch pre-step value", lat0, 6);
    trk(0, 0, 0);
    set_mode(mw(2'd0, 0, 0, 3'd0, 3'd5, 3'd6));
    ctrl(5'b10000);
    cpulse();
    chk("R11 latch0 next mark", lat0, 7);
    chk("R11 latch1 not first", lat1, 6);
    bpulse(0);
    cpulse();
    chk("R13 latch0 next once", lat0, 7);
    chk("R11 latch1 second mark", lat1, 8);
    bpulse(0);
    cpulse();
    chk("R13 latch0 third", lat0, 7);
    chk("R13 latch1 third", lat1, 8);
    set_mode(mw(2'd0, 0, 0, 3'd0, 3'd7, 3'd0));
    cpulse();
    chk("R11 latch0 every", lat0, 9);
    bpulse(0);
    cpulse();
    chk("R11 latch0 every again", lat0, 10);
    set_mode(mw(2'd0, 0, 0, 3'd0, 3'd0, 3'd0));
    bpulse(0);
    ctrl(5'b01100);
    chk("R6 sw latch0", lat0, 11);
    chk("R6 sw latch1", lat1, 11);

    // reference qualification in quadrature
    set_mode(mw(2'd3, 0, 0, 3'd4, 3'd0, 3'd0));
    ctrl(5'b10000);
    trk(0, 0, 1);
    chk("R5 C alone not a mark", {31'd0, ref1}, 0);
    chk("R5 count held", count, 11);
    trk(1, 0, 1);
    chk("R5 step before mark", count, 12);
    trk(1, 1, 1);
    chk("R5 mark at A=B=1", count, 50);
    chk("R5 flag at A=B=1", {31'd0, ref1}, 1);
    trk(1, 0, 1);
    trk(0, 0, 1);
    trk(0, 0, 0);
    chk("R3 reverse after load", count, 48);
    set_mode(mw(2'd3, 0, 1, 3'd4, 3'd0, 3'd0));
    ctrl(5'b10000);
    trk(0, 0, 1);
    chk("R5 inverted mark at raw 00", count, 50);
    chk("R5 inverted flag", {31'd0, ref1}, 1);
    trk(0, 0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule